// File: doc/BRIEF.md
# Cubic B-spline Fractional-Position Reconstruction Filter

This block rebuilds a signal at an arbitrary instant between two input samples. It receives a stream of cubic B-spline coefficients, each accepted with a strobe, and keeps the four most recent ones as a sliding window. A separate strobe supplies a fractional position mu for each output sample wanted. For every mu strobe the block forms the four polynomial branch values of the cubic B-spline basis from the window. It uses shifts and adds only, because every basis weight is a small integer. It then evaluates the cubic in mu by nested (Horner) multiplication, one register stage per multiply, and scales the result by one sixth through a fixed-point reciprocal. The value is rounded to nearest and clamped to the output width.

The strobe that carries mu is meant to be driven by a timing-recovery loop, and the coefficient strobe by a prefilter upstream. Both are outside this block. One output with a valid flag comes out for each mu strobe, after a fixed latency and in the order of the strobes. The strobes may arrive on consecutive cycles.

Top module: `spline_farrow_recon`

## Requirements
- R1: Each cycle with `coef_valid` high shifts `coef_in` into the window as the newest entry and drops the oldest. A mu strobe uses the window as it stood before that cycle, so a coefficient accepted in the same cycle as a mu strobe is not yet part of that result. Window entries, oldest to newest, are c(k-1), c(k), c(k+1), c(k+2).
- R2: For a strobe with `mu_in` = m, let u = m/256. The output is within 1 LSB of (1/6)·(b0 + b1·u + b2·u² + b3·u³), where b0 = c(k-1)+4c(k)+c(k+1), b1 = 3c(k+1)-3c(k-1), b2 = 3c(k-1)-6c(k)+3c(k+1), b3 = c(k+2)-c(k-1)+3c(k)-3c(k+1). All values are two's-complement integers.
- R3: With `mu_in` = 0 and c(k-1)+4c(k)+c(k+1) an exact multiple of 6, the output equals that sum divided by 6 exactly.
- R4: When all four window entries equal one value v, the output is exactly v for every mu. This holds for the extreme values +32767 and -32768.
- R5: `y_valid` rises exactly 6 clock edges after the edge that samples a mu strobe, counting that edge as the first. It produces one single-cycle pulse per strobe. Strobes on consecutive cycles give outputs on consecutive cycles, in strobe order.
- R6: While `y_valid` is low, `y_out` keeps its last value.
- R7: Synchronous active-high `rst` clears the window to zero, drops `y_valid` and sets `y_out` to 0. After reset, a mu strobe with no coefficients loaded yields 0.
- R8: A mu strobe without `coef_valid` leaves the window unchanged, so two strobes with equal mu give equal outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coef_valid | input | 1 | Accept `coef_in` into the window this cycle |
| coef_in | input | CW (16) | Signed spline coefficient |
| mu_valid | input | 1 | Request one output at position `mu_in` |
| mu_in | input | MUW (8) | Unsigned fraction, value mu_in/2^MUW in [0,1) |
| y_valid | output | 1 | `y_out` holds a new sample this cycle |
| y_out | output | CW (16) | Signed reconstructed sample, rounded and saturated |

## Verification
The hardest case to reach is a mu strobe in the same cycle that a new coefficient enters. That is where the window ordering and the pipeline capture meet. The bench loads a window of known values, then raises both strobes together with mu = 0, and expects the old-window result. A second strobe with mu = 0 must then show the shifted window. The stimulus also includes a full mu sweep issued back to back, so that every pipeline stage holds a different mu at once. A wrong hand-off of mu between stages then shows up as a value error.

// File: rtl/spline_pkg.sv
package spline_pkg;
  // Register stages from the mu strobe to y_out:
  // branch, three Horner stages, reciprocal product, round/saturate.
  localparam int LATENCY = 6;

  // Reciprocal of six in 2^rs fixed point, rounded upward.
  function automatic longint sixth_recip(input int rs);
    return ((longint'(1) <<< rs) + 5) / 6;
  endfunction
endpackage

// File: rtl/spline_window.sv
module spline_window #(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic [CW-1:0]        din,
  output logic [3:0][CW-1:0]   win
);
  // win[0] is the oldest entry, win[3] the newest.
  always_ff @(posedge clk) begin
    if (rst) begin
      win <= '0;
    end else if (shift_en) begin
      win <= {din, win[3:1]};
    end
  end
endmodule

// File: rtl/spline_branch.sv
module spline_branch #(
  parameter int CW  = 16,
  parameter int MUW = 8,
  parameter int BW  = CW + 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [3:0][CW-1:0]   win,
  input  logic [MUW-1:0]       mu,
  output logic [3:0][BW-1:0]   bq,
  output logic [MUW-1:0]       mu_q,
  output logic                 vld_q
);
  logic signed [BW-1:0] cm1, c0, c1, c2;
  logic signed [BW-1:0] dif_out, bend, skew;
  logic signed [BW-1:0] br0, br1, br2, br3;

  always_comb begin
    cm1 = BW'($signed(win[0]));
    c0  = BW'($signed(win[1]));
    c1  = BW'($signed(win[2]));
    c2  = BW'($signed(win[3]));
    dif_out = c1 - cm1;
    bend    = cm1 + c1 - (c0 <<< 1);
    skew    = c0 - c1;
    br0 = cm1 + (c0 <<< 2) + c1;
    br1 = (dif_out <<< 1) + dif_out;
    br2 = (bend <<< 1) + bend;
    br3 = c2 - cm1 + (skew <<< 1) + skew;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      bq    <= '0;
      mu_q  <= '0;
    end else begin
      vld_q <= en;
      if (en) begin
        bq   <= {br3, br2, br1, br0};
        mu_q <= mu;
      end
    end
  end
endmodule

// File: rtl/spline_horner_stage.sv
module spline_horner_stage #(
  parameter int MUW   = 8,
  parameter int BW    = 20,
  parameter int ACC_W = 46,
  parameter int SHIFT = 8,
  parameter int SEL   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_in,
  input  logic [ACC_W-1:0]     acc_in,
  input  logic [3:0][BW-1:0]   b_in,
  input  logic [MUW-1:0]       mu_in,
  output logic                 vld_out,
  output logic [ACC_W-1:0]     acc_out,
  output logic [3:0][BW-1:0]   b_out,
  output logic [MUW-1:0]       mu_out
);
  logic signed [ACC_W-1:0] mu_ext, b_ext, acc_s, nxt;

  always_comb begin
    mu_ext = ACC_W'($signed({1'b0, mu_in}));
    b_ext  = ACC_W'($signed(b_in[SEL]));
    acc_s  = $signed(acc_in);
    nxt    = acc_s * mu_ext + (b_ext <<< SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out <= 1'b0;
      acc_out <= '0;
      b_out   <= '0;
      mu_out  <= '0;
    end else begin
      vld_out <= vld_in;
      if (vld_in) begin
        acc_out <= nxt;
        b_out   <= b_in;
        mu_out  <= mu_in;
      end
    end
  end
endmodule

// File: rtl/spline_scale.sv
module spline_scale #(
  parameter int CW    = 16,
  parameter int ACC_W = 46,
  parameter int FRAC  = 24,
  parameter int RS    = 20,
  parameter int PW    = ACC_W + RS + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_in,
  input  logic [ACC_W-1:0]  acc_in,
  output logic              y_valid,
  output logic [CW-1:0]     y_out
);
  localparam int SH = FRAC + RS;
  localparam logic signed [PW-1:0] RECIP = PW'(spline_pkg::sixth_recip(RS));
  localparam logic signed [PW-1:0] HALF  = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] YMAX  = PW'((longint'(1) <<< (CW - 1)) - 1);
  localparam logic signed [PW-1:0] YMIN  = -(PW'(longint'(1) <<< (CW - 1)));

  logic signed [PW-1:0] prod_q, rounded;
  logic                 pvld_q;
  logic signed [CW-1:0] y_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pvld_q <= 1'b0;
      prod_q <= '0;
    end else begin
      pvld_q <= vld_in;
      if (vld_in) prod_q <= PW'($signed(acc_in)) * RECIP;
    end
  end

  always_comb begin
    rounded = (prod_q + HALF) >>> SH;
    if (rounded > YMAX)      y_nxt = YMAX[CW-1:0];
    else if (rounded < YMIN) y_nxt = YMIN[CW-1:0];
    else                     y_nxt = rounded[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_valid <= 1'b0;
      y_out   <= '0;
    end else begin
      y_valid <= pvld_q;
      if (pvld_q) y_out <= y_nxt;
    end
  end
endmodule

// File: rtl/spline_farrow_recon.sv
module spline_farrow_recon #(
  parameter int CW  = 16,
  parameter int MUW = 8,
  parameter int RS  = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            coef_valid,
  input  logic [CW-1:0]   coef_in,
  input  logic            mu_valid,
  input  logic [MUW-1:0]  mu_in,
  output logic            y_valid,
  output logic [CW-1:0]   y_out
);
  localparam int BW     = CW + 4;
  localparam int NSTAGE = 3;
  localparam int FRAC   = NSTAGE * MUW;
  localparam int ACC_W  = BW + FRAC + 2;

  logic [3:0][CW-1:0] win;
  logic [3:0][BW-1:0] b_q;
  logic [MUW-1:0]     mu_b;
  logic               vld_b;

  logic [NSTAGE:0]            h_vld;
  logic [ACC_W-1:0]           h_acc [NSTAGE+1];
  logic [3:0][BW-1:0]         h_b   [NSTAGE+1];
  logic [MUW-1:0]             h_mu  [NSTAGE+1];

  spline_window #(.CW(CW)) win_i (
    .clk(clk), .rst(rst), .shift_en(coef_valid), .din(coef_in), .win(win)
  );

  spline_branch #(.CW(CW), .MUW(MUW), .BW(BW)) br_i (
    .clk(clk), .rst(rst), .en(mu_valid), .win(win), .mu(mu_in),
    .bq(b_q), .mu_q(mu_b), .vld_q(vld_b)
  );

  // Horner chain starts from the cubic branch.
  assign h_vld[0] = vld_b;
  assign h_acc[0] = ACC_W'($signed(b_q[3]));
  assign h_b[0]   = b_q;
  assign h_mu[0]  = mu_b;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_horner
    spline_horner_stage #(
      .MUW(MUW), .BW(BW), .ACC_W(ACC_W),
      .SHIFT(MUW * (k + 1)), .SEL(NSTAGE - 1 - k)
    ) st_i (
      .clk(clk), .rst(rst),
      .vld_in(h_vld[k]), .acc_in(h_acc[k]), .b_in(h_b[k]), .mu_in(h_mu[k]),
      .vld_out(h_vld[k+1]), .acc_out(h_acc[k+1]), .b_out(h_b[k+1]),
      .mu_out(h_mu[k+1])
    );
  end

  spline_scale #(.CW(CW), .ACC_W(ACC_W), .FRAC(FRAC), .RS(RS)) sc_i (
    .clk(clk), .rst(rst), .vld_in(h_vld[NSTAGE]), .acc_in(h_acc[NSTAGE]),
    .y_valid(y_valid), .y_out(y_out)
  );
endmodule

// File: rtl/spline_farrow_recon_chk.sv
module spline_farrow_recon_chk #(
  parameter int CW  = 16,
  parameter int LAT = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               coef_valid,
  input logic [CW-1:0]      coef_in,
  input logic               mu_valid,
  input logic               y_valid,
  input logic [CW-1:0]      y_out,
  input logic [3:0][CW-1:0] win
);
  logic [LAT-1:0] strobe_sh;
  always_ff @(posedge clk) begin
    if (rst) strobe_sh <= '0;
    else     strobe_sh <= {strobe_sh[LAT-2:0], mu_valid};
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    y_valid == strobe_sh[LAT-1]);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> $stable(y_out));

  assert_reset_R7: assert property (@(posedge clk)
    rst |=> (!y_valid && y_out == '0 && win == '0));

  assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
    coef_valid |=> (win[3] == $past(coef_in) && win[2:0] == $past(win[3:1])));

  assert_keep_window_R8: assert property (@(posedge clk) disable iff (rst)
    !coef_valid |=> $stable(win));
endmodule

bind spline_farrow_recon spline_farrow_recon_chk #(
  .CW(CW), .LAT(spline_pkg::LATENCY)
) chk_i (
  .clk(clk), .rst(rst), .coef_valid(coef_valid), .coef_in(coef_in),
  .mu_valid(mu_valid), .y_valid(y_valid), .y_out(y_out), .win(win)
);

// File: tb/spline_farrow_recon_tb.sv
module spline_farrow_recon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // each row: c(k-1), c(k), c(k+1), c(k+2), mu
  localparam int VEC [NV][5] = '{
    '{100, 200, 300, 400, 64},
    '{-500, 1200, -800, 3000, 128},
    '{32767, -32768, 32767, -32768, 200},
    '{-32768, 32767, -32768, 32767, 33},
    '{0, 0, 10000, 0, 255},
    '{7, -7, 7, -7, 1},
    '{12000, 12000, -12000, -12000, 90},
    '{-1, 0, 1, 2, 170},
    '{25000, -3000, 18000, 500, 17},
    '{-20000, -19000, -21000, -18000, 240},
    '{5, 1000, 20000, 32000, 128},
    '{31000, 0, -31000, 0, 77}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coef_valid = 1'b0;
  logic [15:0] coef_in = '0;
  logic mu_valid = 1'b0;
  logic [7:0] mu_in = '0;
  logic y_valid;
  logic [15:0] y_out;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int qv[$];
  int qc[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spline_farrow_recon dut_i (
    .clk(clk), .rst(rst), .coef_valid(coef_valid), .coef_in(coef_in),
    .mu_valid(mu_valid), .mu_in(mu_in), .y_valid(y_valid), .y_out(y_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (y_valid) begin
      qv.push_back(int'($signed(y_out)));
      qc.push_back(cyc);
    end
  end

  function automatic real model(int a, int b, int c, int d, int m);
    real u, b0, b1, b2, b3;
    u  = real'(m) / 256.0;
    b0 = real'(a + 4*b + c);
    b1 = real'(3*c - 3*a);
    b2 = real'(3*a - 6*b + 3*c);
    b3 = real'(d - a + 3*b - 3*c);
    return (b0 + u*(b1 + u*(b2 + u*b3))) / 6.0;
  endfunction

  task automatic check_int(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_near(string req, int got, real exp);
    real diff;
    n_checks++;
    diff = real'(got) - exp;
    if (diff < 0.0) diff = -diff;
    if (diff > 1.0) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %f", req, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic push_coef(int c);
    coef_in = 16'(c);
    coef_valid = 1'b1;
    @(negedge clk);
    coef_valid = 1'b0;
  endtask

  task automatic load4(int a, int b, int c, int d);
    push_coef(a); push_coef(b); push_coef(c); push_coef(d);
  endtask

  task automatic strobe(int m, output int at);
    at = cyc;
    mu_in = 8'(m);
    mu_valid = 1'b1;
    @(negedge clk);
    mu_valid = 1'b0;
  endtask

  task automatic pop(string req, output int v, output int c);
    int w;
    w = 0;
    while (qv.size() == 0 && w < 30) begin
      @(negedge clk);
      w++;
    end
    if (qv.size() == 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL %s: got no output expected one", req);
      v = 0; c = 0;
    end else begin
      v = qv.pop_front();
      c = qc.pop_front();
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int v, c, at, v2;
    int ats[16];
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    check_int("R7 reset y_valid", int'(y_valid), 0);
    check_int("R7 reset y_out", int'($signed(y_out)), 0);
    rst = 1'b0;
    @(negedge clk);

    // R7 empty window, R5 latency
    strobe(128, at);
    pop("R7", v, c);
    check_int("R7 empty window", v, 0);
    check_int("R5 latency", c - at, 6);

    // R2 vector table
    for (int i = 0; i < NV; i++) begin
      load4(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      strobe(VEC[i][4], at);
      pop("R2", v, c);
      check_near("R2 table", v,
        model(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]));
    end

    // R2 sweep of mu, back to back for R5 ordering
    load4(-1200, 5000, -300, 8000);
    mu_valid = 1'b1;
    for (int i = 0; i < 16; i++) begin
      mu_in = 8'(i * 17);
      ats[i] = cyc;
      @(negedge clk);
    end
    mu_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pop("R5", v, c);
      check_near("R2 sweep", v, model(-1200, 5000, -300, 8000, i * 17));
      check_int("R5 back-to-back latency", c - ats[i], 6);
    end

    // R3 exact at mu = 0: (6 - 48 + 30)/6 = -2
    load4(6, -12, 30, 999);
    strobe(0, at);
    pop("R3", v, c);
    check_int("R3 mu zero", v, -2);
    load4(600, 1500, -6, -4000);
    strobe(0, at);
    pop("R3", v, c);
    check_int("R3 mu zero second", v, 1099);

    // R4 constant window, extremes
    load4(32767, 32767, 32767, 32767);
    strobe(200, at);
    pop("R4", v, c);
    check_int("R4 const max", v, 32767);
    load4(-32768, -32768, -32768, -32768);
    strobe(255, at);
    pop("R4", v, c);
    check_int("R4 const min", v, -32768);
    load4(-777, -777, -777, -777);
    strobe(91, at);
    pop("R4", v, c);
    check_int("R4 const mid", v, -777);

    // R1 coefficient and mu in the same cycle
    load4(10, 20, 30, 40);
    coef_in = 16'(1000);
    coef_valid = 1'b1;
    mu_in = 8'd0;
    mu_valid = 1'b1;
    at = cyc;
    @(negedge clk);
    coef_valid = 1'b0;
    mu_valid = 1'b0;
    pop("R1", v, c);
    check_int("R1 same-cycle uses old window", v, 20);
    strobe(0, at);
    pop("R1", v, c);
    check_int("R1 shifted window", v, 30);

    // R8 repeated mu without coefficients
    strobe(150, at);
    pop("R8", v, c);
    strobe(150, at);
    pop("R8", v2, c);
    check_int("R8 window kept", v2, v);
    check_near("R8 value", v, model(20, 30, 40, 1000, 150));

    // R6 hold while idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_int("R6 idle valid", int'(y_valid), 0);
      check_int("R6 idle hold", int'($signed(y_out)), v2);
    end

    done = 1'b1;
    finish_run();
  end
endmodule